// File: doc/BRIEF.md
# Predicated Floating-Point Compare-Against-Zero Unit

This block takes a whole vector of packed IEEE 754 elements and tests each element against zero under a governing predicate. It produces a result predicate plus the invalid-operation exception. Elements may be half, single or double precision. The condition is one of six relations: at-least, above, at-most, below, equal or unequal.

Both the governing predicate and the result predicate hold one bit per vector byte. Each element is represented only by the bit at its lowest byte. The block also decodes the condition and size fields of the instruction it serves, and it flags combinations that do not belong to this operation group.

The whole vector is evaluated combinationally in one pass. The result is registered, so it appears in the cycle after the request together with a one-cycle valid pulse. Exceptions raised by half-precision work are reported on their own output, because that precision keeps a separate status context from single and double precision.

Top module: `fp_zero_compare`

## Requirements
- R1: `sizeCode` selects the element width: 1 gives 16 bits, 2 gives 32 bits and 3 gives 64 bits. Code 0 is illegal: the response shows `illegal`=1, `resPred`=0 and both flags 0.
- R2: `{opSel,lowBit}` selects the condition: 00,0 is x>=0; 00,1 is x>0; 01,0 is x<0; 01,1 is x<=0; 10,0 is x==0; 11,0 is x!=0. The codes 10,1 and 11,1 are illegal and respond like R1's illegal case.
- R3: An element is active when `govPred` is 1 at the element's lowest byte index. Only that byte index of `resPred` can carry the outcome. Every other bit of the element is 0, and an inactive element gives all zeros.
- R4: Zero of either sign counts as zero. Infinities and subnormals compare by their sign, as nonzero values.
- R5: A NaN element (exponent all ones, fraction nonzero) gives false for x>=0, x>0, x<=0, x<0 and x==0, and gives true for x!=0.
- R6: For the four ordered conditions, any active NaN raises the invalid flag. For x==0 and x!=0, only an active signalling NaN raises it. A signalling NaN has the top fraction bit 0.
- R7: An inactive element never raises the invalid flag, whatever its value.
- R8: The invalid flag goes to `invalidFlagHalf` for 16-bit elements and to `invalidFlag` for 32- and 64-bit elements. The two flags are never set together.
- R9: Every output is registered. `outValid` is 1 in the cycle after `inValid`. When `outValid` is 0, `resPred`, both flags and `illegal` are 0.
- R10: While `rstN` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe for this cycle |
| opSel | input | 2 | Condition opcode bits |
| lowBit | input | 1 | Condition low bit |
| sizeCode | input | 2 | Element size code |
| srcVec | input | VLEN | Packed source elements |
| govPred | input | VLEN/8 | Governing predicate, one bit per byte |
| outValid | output | 1 | Result strobe |
| resPred | output | VLEN/8 | Result predicate, one bit per byte |
| invalidFlag | output | 1 | Invalid operation, single/double context |
| invalidFlagHalf | output | 1 | Invalid operation, half-precision context |
| illegal | output | 1 | Request had an illegal encoding |

## Verification
The bound checker watches the properties that follow from the encoding and timing on every cycle. These are the one-cycle response, quiet outputs between results, the empty response for an illegal size or condition, the exclusive flag context chosen by the size, and the rule that no result bit appears where the governing predicate was 0. Whether each element's outcome is correct for signed zeros, infinities, subnormals and both kinds of NaN only shows in the bench's scenarios. The same holds for the split between signalling and quiet comparisons and for NaNs hidden under inactive elements. There a behavioural model recomputes every response and compares it on each clock.

// File: rtl/fzc_pkg.sv
package fzc_pkg;

  typedef enum logic [2:0] {
    CMP_GE = 3'd0,
    CMP_GT = 3'd1,
    CMP_LT = 3'd2,
    CMP_LE = 3'd3,
    CMP_EQ = 3'd4,
    CMP_NE = 3'd5
  } cmpCond_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     fire;     // a request is accepted this cycle
    logic     bad;      // encoding is outside the group
    cmpCond_e cond;     // decoded relation
    logic [2:0] sizeSel; // one-hot: [0]=16b, [1]=32b, [2]=64b
  } cmpCtrl_t;

  localparam int unsigned NUM_SIZES = 3;

  function automatic int unsigned expBits(input int unsigned width);
    case (width)
      16:      expBits = 5;
      32:      expBits = 8;
      default: expBits = 11;
    endcase
  endfunction

endpackage

// File: rtl/fzc_ctrl.sv
module fzc_ctrl
  import fzc_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic       lowBit,
  input  logic [1:0] sizeCode,
  output cmpCtrl_t   ctrl
);

  logic     condBad;
  cmpCond_e condDec;

  always_comb begin
    condBad = 1'b0;
    condDec = CMP_GE;
    case ({opSel, lowBit})
      3'b000: condDec = CMP_GE;
      3'b001: condDec = CMP_GT;
      3'b010: condDec = CMP_LT;
      3'b011: condDec = CMP_LE;
      3'b100: condDec = CMP_EQ;
      3'b110: condDec = CMP_NE;
      default: condBad = 1'b1;
    endcase
  end

  always_comb begin
    ctrl.fire    = inValid;
    ctrl.cond    = condDec;
    ctrl.sizeSel = 3'b000;
    case (sizeCode)
      2'd1:    ctrl.sizeSel = 3'b001;
      2'd2:    ctrl.sizeSel = 3'b010;
      2'd3:    ctrl.sizeSel = 3'b100;
      default: ctrl.sizeSel = 3'b000;
    endcase
    ctrl.bad = condBad | (sizeCode == 2'd0);
  end

endmodule

// File: rtl/fzc_lane.sv
module fzc_lane
  import fzc_pkg::*;
#(
  parameter int unsigned EW = 32,
  parameter int unsigned XW = 8
) (
  input  logic [EW-1:0] elem,
  input  cmpCond_e      cond,
  input  logic          active,
  output logic          hit,
  output logic          raiseInv
);

  localparam int unsigned MW = EW - 1 - XW;

  logic          signBit;
  logic [XW-1:0] expo;
  logic [MW-1:0] frac;
  logic isNan, isSnan, isZero, posVal, negVal, outcome, ordered;

  assign signBit = elem[EW-1];
  assign expo    = elem[EW-2 -: XW];
  assign frac    = elem[MW-1:0];

  assign isNan  = (&expo) & (|frac);
  assign isSnan = isNan & ~frac[MW-1];
  assign isZero = ~(|expo) & ~(|frac);
  assign posVal = ~isNan & ~isZero & ~signBit;
  assign negVal = ~isNan & ~isZero & signBit;

  always_comb begin
    outcome = 1'b0;
    ordered = 1'b1;
    case (cond)
      CMP_GE: outcome = posVal | (isZero & ~isNan);
      CMP_GT: outcome = posVal;
      CMP_LT: outcome = negVal;
      CMP_LE: outcome = negVal | (isZero & ~isNan);
      CMP_EQ: begin outcome = isZero; ordered = 1'b0; end
      CMP_NE: begin outcome = ~isZero; ordered = 1'b0; end
      default: outcome = 1'b0;
    endcase
  end

  assign hit      = active & outcome;
  assign raiseInv = active & (ordered ? isNan : isSnan);

endmodule

// File: rtl/fzc_datapath.sv
module fzc_datapath
  import fzc_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpCtrl_t          ctrl,
  input  logic [VLEN-1:0]   srcVec,
  input  logic [VLEN/8-1:0] govPred,
  output logic              outValid,
  output logic [VLEN/8-1:0] resPred,
  output logic              invalidFlag,
  output logic              invalidFlagHalf,
  output logic              illegal
);

  localparam int unsigned NB = VLEN / 8;

  logic [NUM_SIZES-1:0][NB-1:0] resAll;
  logic [NUM_SIZES-1:0]         invAll;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int unsigned W   = 16 << g;
    localparam int unsigned NE  = VLEN / W;
    localparam int unsigned BPE = W / 8;
    logic [NE-1:0] hits, invs;

    for (genvar e = 0; e < NE; e++) begin : g_elem
      fzc_lane #(.EW(W), .XW(expBits(W))) i_lane (
        .elem     (srcVec[e*W +: W]),
        .cond     (ctrl.cond),
        .active   (govPred[e*BPE]),
        .hit      (hits[e]),
        .raiseInv (invs[e])
      );
      assign resAll[g][e*BPE +: BPE] = {{(BPE-1){1'b0}}, hits[e]};
    end
    assign invAll[g] = |invs;
  end

  logic [NB-1:0] selRes;
  logic          selInv;

  always_comb begin
    selRes = '0;
    selInv = 1'b0;
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (ctrl.sizeSel[s]) begin
        selRes = resAll[s];
        selInv = invAll[s];
      end
    end
  end

  logic goodReq;
  assign goodReq = ctrl.fire & ~ctrl.bad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid        <= 1'b0;
      resPred         <= '0;
      invalidFlag     <= 1'b0;
      invalidFlagHalf <= 1'b0;
      illegal         <= 1'b0;
    end else begin
      outValid        <= ctrl.fire;
      illegal         <= ctrl.fire & ctrl.bad;
      resPred         <= goodReq ? selRes : '0;
      invalidFlag     <= goodReq & selInv & ~ctrl.sizeSel[0];
      invalidFlagHalf <= goodReq & selInv & ctrl.sizeSel[0];
    end
  end

endmodule

// File: rtl/fp_zero_compare.sv
module fp_zero_compare
  import fzc_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic              lowBit,
  input  logic [1:0]        sizeCode,
  input  logic [VLEN-1:0]   srcVec,
  input  logic [VLEN/8-1:0] govPred,
  output logic              outValid,
  output logic [VLEN/8-1:0] resPred,
  output logic              invalidFlag,
  output logic              invalidFlagHalf,
  output logic              illegal
);

  cmpCtrl_t ctrl;

  fzc_ctrl i_ctrl (
    .inValid  (inValid),
    .opSel    (opSel),
    .lowBit   (lowBit),
    .sizeCode (sizeCode),
    .ctrl     (ctrl)
  );

  fzc_datapath #(.VLEN(VLEN)) i_dp (
    .clk             (clk),
    .rstN            (rstN),
    .ctrl            (ctrl),
    .srcVec          (srcVec),
    .govPred         (govPred),
    .outValid        (outValid),
    .resPred         (resPred),
    .invalidFlag     (invalidFlag),
    .invalidFlagHalf (invalidFlagHalf),
    .illegal         (illegal)
  );

endmodule

// File: rtl/fzc_checker.sv
module fzc_checker #(
  parameter int unsigned VLEN = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              condHi,
  input logic              lowBit,
  input logic [1:0]        sizeCode,
  input logic [VLEN/8-1:0] govPred,
  input logic              outValid,
  input logic [VLEN/8-1:0] resPred,
  input logic              invalidFlag,
  input logic              invalidFlagHalf,
  input logic              illegal
);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (resPred == '0 && !invalidFlag && !invalidFlagHalf && !illegal));

  p_size_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode == 2'd0) |=> illegal);

  p_cond_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condHi && lowBit) |=> illegal);

  p_illegal_empty_r1: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (resPred == '0 && !invalidFlag && !invalidFlagHalf));

  p_inactive_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ((resPred & ~$past(govPred)) == '0));

  p_half_ctx_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode == 2'd1) |=> !invalidFlag);

  p_wide_ctx_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode != 2'd1) |=> !invalidFlagHalf);

endmodule

bind fp_zero_compare fzc_checker #(.VLEN(VLEN)) i_fzc_checker (
  .clk             (clk),
  .rstN            (rstN),
  .inValid         (inValid),
  .condHi          (opSel[1]),
  .lowBit          (lowBit),
  .sizeCode        (sizeCode),
  .govPred         (govPred),
  .outValid        (outValid),
  .resPred         (resPred),
  .invalidFlag     (invalidFlag),
  .invalidFlagHalf (invalidFlagHalf),
  .illegal         (illegal)
);

// File: tb/test_fp_zero_compare.sv
module test_fp_zero_compare;

  localparam int VLEN = 256;
  localparam int NB   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 1'b0;
  logic [1:0]      opSel = '0;
  logic            lowBit = 1'b0;
  logic [1:0]      sizeCode = '0;
  logic [VLEN-1:0] srcVec = '0;
  logic [NB-1:0]   govPred = '0;
  logic            outValid, invalidFlag, invalidFlagHalf, illegal;
  logic [NB-1:0]   resPred;

  int    errors = 0;
  int    checks = 0;
  string curReq = "R10";
  bit    running = 1'b0;

  always #4 clk = ~clk;

  fp_zero_compare #(.VLEN(VLEN)) i_fp_zero_compare (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .lowBit(lowBit),
    .sizeCode(sizeCode), .srcVec(srcVec), .govPred(govPred), .outValid(outValid),
    .resPred(resPred), .invalidFlag(invalidFlag), .invalidFlagHalf(invalidFlagHalf),
    .illegal(illegal)
  );

  // behavioural reference: one element at a time, widths from the size code
  function automatic void refModel(input logic [1:0] sz, input logic [1:0] op, input logic lb,
                                   input logic [VLEN-1:0] v, input logic [NB-1:0] g,
                                   output logic [NB-1:0] r, output logic inv,
                                   output logic invH, output logic ill);
    int ebytes, ew, expw, manw, ex;
    logic [63:0] e, m;
    bit s, nan, snan, zero, res, flag;
    ill = (sz == 2'd0) || (op[1] && lb);
    r = '0; inv = 1'b0; invH = 1'b0;
    if (ill) return;
    ebytes = 1 << sz;
    ew = ebytes * 8;
    expw = (sz == 2'd1) ? 5 : (sz == 2'd2) ? 8 : 11;
    manw = ew - 1 - expw;
    for (int b = 0; b < NB; b += ebytes) begin
      if (!g[b]) continue;
      e = '0;
      for (int k = 0; k < ew; k++) e[k] = v[b*8 + k];
      m = e & ((64'd1 << manw) - 64'd1);
      ex = int'((e >> manw) & ((64'd1 << expw) - 64'd1));
      s = e[ew-1];
      nan = (ex == (1 << expw) - 1) && (m != 0);
      snan = nan && !e[manw-1];
      zero = (ex == 0) && (m == 0);
      case ({op, lb})
        3'b000: res = !nan && (zero || !s);
        3'b001: res = !nan && !zero && !s;
        3'b010: res = !nan && !zero && s;
        3'b011: res = !nan && (zero || s);
        3'b100: res = !nan && zero;
        default: res = nan || !zero;
      endcase
      flag = op[1] ? snan : nan;
      if (flag) begin
        if (sz == 2'd1) invH = 1'b1; else inv = 1'b1;
      end
      r[b] = res;
    end
  endfunction

  logic          expValid, expInv, expInvH, expIll;
  logic [NB-1:0] expRes;

  always @(posedge clk or negedge rstN) begin
    logic [NB-1:0] r; logic a, b, c;
    if (!rstN) begin
      expValid <= 0; expRes <= '0; expInv <= 0; expInvH <= 0; expIll <= 0;
    end else begin
      refModel(sizeCode, opSel, lowBit, srcVec, govPred, r, a, b, c);
      expValid <= inValid;
      expRes   <= inValid ? r : '0;
      expInv   <= inValid & a;
      expInvH  <= inValid & b;
      expIll   <= inValid & c;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (outValid !== expValid || resPred !== expRes || invalidFlag !== expInv ||
          invalidFlagHalf !== expInvH || illegal !== expIll) begin
        errors++;
        $display("FAIL %s: got v=%b res=%h inv=%b invH=%b ill=%b expected v=%b res=%h inv=%b invH=%b ill=%b",
                 curReq, outValid, resPred, invalidFlag, invalidFlagHalf, illegal,
                 expValid, expRes, expInv, expInvH, expIll);
      end
    end
  end

  function automatic logic [VLEN-1:0] putElem(input logic [VLEN-1:0] v, input int sz,
                                             input int idx, input logic [63:0] val);
    int ew;
    ew = 8 << sz;
    for (int k = 0; k < ew; k++) v[idx*ew + k] = val[k];
    return v;
  endfunction

  task automatic issue(input logic [1:0] sz, input logic [2:0] cnd,
                       input logic [VLEN-1:0] v, input logic [NB-1:0] g, input string req);
    @(negedge clk); #1;
    inValid = 1'b1; sizeCode = sz; opSel = cnd[2:1]; lowBit = cnd[0];
    srcVec = v; govPred = g; curReq = req;
  endtask

  task automatic idle(input string req);
    @(negedge clk); #1;
    inValid = 1'b0; srcVec = {8{$urandom}}; govPred = $urandom; curReq = req;
  endtask

  logic [2:0] conds [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b110};

  initial begin
    logic [VLEN-1:0] vh, vs, vd, vmix;
    logic [63:0] hv [16] = '{64'h0000, 64'h8000, 64'h3C00, 64'hBC00, 64'h7C00, 64'hFC00,
                             64'h7E00, 64'h7C01, 64'h0001, 64'h8001, 64'hFE00, 64'hFC01,
                             64'h7BFF, 64'hFBFF, 64'h03FF, 64'h4000};
    logic [63:0] sv [8] = '{64'h0, 64'h80000000, 64'h3F800000, 64'hBF800000,
                            64'h7F800000, 64'hFF800000, 64'h7FC00000, 64'h7F800001};
    logic [63:0] dv [4] = '{64'h8000000000000000, 64'h0000000000000001,
                            64'h7FF0000000000001, 64'hFFF8000000000000};
    // R10: reset state
    repeat (2) @(negedge clk);
    checks++;
    if (outValid !== 0 || resPred !== '0 || invalidFlag !== 0 || invalidFlagHalf !== 0 || illegal !== 0) begin
      errors++;
      $display("FAIL R10: outputs %b %h %b %b %b expected all zero", outValid, resPred,
               invalidFlag, invalidFlagHalf, illegal);
    end
    #1 rstN = 1'b1;
    running = 1'b1;
    idle("R9");

    vh = '0; vs = '0; vd = '0;
    for (int i = 0; i < 16; i++) vh = putElem(vh, 1, i, hv[i]);
    for (int i = 0; i < 8; i++)  vs = putElem(vs, 2, i, sv[i]);
    for (int i = 0; i < 4; i++)  vd = putElem(vd, 3, i, dv[i]);

    // R4 R5 R6 R8: every condition on each size, all active
    foreach (conds[c]) issue(2'd1, conds[c], vh, '1, "R4 R5 R6 R8 half");
    foreach (conds[c]) issue(2'd2, conds[c], vs, '1, "R4 R5 R6 R8 single");
    foreach (conds[c]) issue(2'd3, conds[c], vd, '1, "R4 R5 R6 R8 double");
    idle("R9");

    // R3 R7: predicate bits only on non-lowest bytes, then mixed
    foreach (conds[c]) issue(2'd1, conds[c], vh, 32'hAAAA_AAAA, "R3 R7 upper bytes only");
    foreach (conds[c]) issue(2'd2, conds[c], vs, 32'h1234_5671, "R3 R7 mixed");
    vmix = '0;
    for (int i = 0; i < 16; i++) vmix = putElem(vmix, 1, i, (i % 2) ? 64'h7C01 : 64'h3C00);
    issue(2'd1, 3'b000, vmix, 32'h5555_5555, "R7 nan inactive");
    issue(2'd1, 3'b110, vmix, 32'h5555_5555, "R7 nan inactive ne");
    issue(2'd3, 3'b011, vd, 32'h0000_0101, "R3 R7 double");

    // R1 R2: illegal encodings
    issue(2'd0, 3'b000, vh, '1, "R1 size zero");
    issue(2'd2, 3'b101, vs, '1, "R2 gap 10/1");
    issue(2'd3, 3'b111, vd, '1, "R2 gap 11/1");
    idle("R9"); idle("R9");

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 4 == 0) idle("R9 random idle");
      else issue(2'($urandom), 3'($urandom), {8{$urandom}}, $urandom, "R3 R4 R5 R6 random");
    end
    idle("R9"); idle("R9");
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule